// File: doc/BRIEF.md
# LIN Break Field Generator

This block starts a LIN master frame by driving the break and its delimiter onto the transmit line. It counts pulses of a clock enable that runs at eight times the bit rate. One counter spans the whole field: for the first thirteen bit times the line is pulled dominant (low), and for the final bit time it is released recessive (high). When the field ends, a one-cycle completion pulse tells the next stage to send the sync byte 0x55.

The block takes control of the line only while a break is running. Once the line has gone high in the delimiter, a hold flag keeps it high until the block lets go. The counter wrapping at the end of the field therefore cannot produce a falling edge that a slave would take as the start of the sync byte. A bit error reported during the break ends the field at once. The block then returns to idle and can be restarted.

Top module: `lin_break_gen`

## Requirements
- R1: After reset, `tx_o` is 1 (recessive), `busy_o` is 0 and `done_o` is 0.
- R2: A `start_i` pulse while idle is accepted on that clock edge. In the following cycle `tx_o` is 0 and `busy_o` is 1.
- R3: The field advances only on clock edges where `baud_tick_i` is 1 and the block is busy. The tick present on the accepting edge is not counted. With no ticks, the block stays busy with `tx_o` low for any length of time.
- R4: `tx_o` stays 0 until 104 ticks (13 bit times at 8 ticks per bit) have been counted after acceptance.
- R5: After the 104th tick `tx_o` is 1, and it has no falling edge for the rest of the field.
- R6: On the edge of the 112th tick (14 bit times; terminal count value 111), `done_o` pulses high for exactly one cycle and `busy_o` falls in the same cycle, with `tx_o` at 1.
- R7: `bit_err_i` high on an edge while busy aborts the field. In the next cycle `busy_o` is 0, `tx_o` is 1 and `done_o` stays 0, and a later `start_i` begins a new field.
- R8: A `start_i` while busy is ignored. The timing of the field in progress is unchanged.
- R9: `bit_err_i` while idle has no effect: `tx_o` stays 1, and neither `busy_o` nor `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | Clock enable at eight times the bit rate |
| start_i | input | 1 | Request to begin a break field |
| bit_err_i | input | 1 | Bit error reported by the line monitor |
| tx_o | output | 1 | Transmit line, 1 = recessive |
| busy_o | output | 1 | High while the block owns the line |
| done_o | output | 1 | One-cycle pulse at the end of the delimiter |

## Verification
Fields are run with ticks on every cycle, ticks every few cycles, and sparse random ticks. Matching results across these patterns show that the timing depends on the tick count and not on clock cycles. A directed run with no ticks for hundreds of cycles shows that the counter never advances by itself. Start requests in the middle of a field are separated from real restarts by checking that the low and high spans keep their full lengths. Bit errors are injected both at the start of a field and deep into the delimiter, and pulsed while idle. This distinguishes a true abort from a completion and confirms that an idle error does nothing.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

  typedef enum logic {
    BRK_IDLE = 1'b0,
    BRK_RUN  = 1'b1
  } brk_state_e;

  // ticks in the whole field (break plus delimiter)
  function automatic int unsigned field_ticks(input int unsigned os,
                                              input int unsigned low_bits,
                                              input int unsigned high_bits);
    return os * (low_bits + high_bits);
  endfunction

  // ticks during which the line is dominant
  function automatic int unsigned low_ticks(input int unsigned os,
                                            input int unsigned low_bits);
    return os * low_bits;
  endfunction

  // last counter value before the wrap
  function automatic int unsigned last_count(input int unsigned os,
                                             input int unsigned low_bits,
                                             input int unsigned high_bits);
    return field_ticks(os, low_bits, high_bits) - 1;
  endfunction

endpackage

// File: rtl/lin_brk_counter.sv
module lin_brk_counter #(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned LAST   = 111,
  parameter int unsigned LOW_N  = 104
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             low_end_o,
  output logic             last_hit_o
);

  localparam logic [CNT_W-1:0] LAST_V   = CNT_W'(LAST);
  localparam logic [CNT_W-1:0] LOW_PREV = CNT_W'(LOW_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             step_w;

  assign step_w     = run_i && tick_i;
  assign last_hit_o = step_w && (cnt_q == LAST_V);
  assign low_end_o  = step_w && (cnt_q == LOW_PREV);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i || last_hit_o) begin
      cnt_q <= '0;
    end else if (step_w) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !clear_i && cnt_q != LAST_V) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clear_i) |=> $stable(cnt_q));

  assert_never_past_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_V);

endmodule

// File: rtl/lin_brk_ctrl.sv
module lin_brk_ctrl
  import lin_brk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bit_err_i,
  input  logic last_hit_i,
  output logic active_o,
  output logic accept_o,
  output logic abort_o,
  output logic finish_o,
  output logic done_o
);

  brk_state_e state_q;
  logic       done_q;

  assign active_o = (state_q == BRK_RUN);
  assign accept_o = !active_o && start_i;
  assign abort_o  = active_o && bit_err_i;
  assign finish_o = active_o && last_hit_i && !bit_err_i;
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BRK_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_o;
      if (accept_o) begin
        state_q <= BRK_RUN;
      end else if (abort_o || finish_o) begin
        state_q <= BRK_IDLE;
      end
    end
  end

  assert_accept_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> active_o);

  assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && bit_err_i) |=> (!active_o && !done_o));

  assert_idle_err_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !start_i && bit_err_i) |=> (!active_o && !done_o));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/lin_brk_txguard.sv
module lin_brk_txguard (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic low_end_i,
  input  logic release_i,
  output logic tx_o,
  output logic hold_o
);

  logic pull_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (release_i) begin
      pull_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (accept_i) begin
      pull_q <= 1'b1;
      hold_q <= 1'b0;
    end else if (low_end_i) begin
      pull_q <= 1'b0;
      hold_q <= 1'b1;
    end
  end

  assign tx_o   = hold_q || !pull_q;
  assign hold_o = hold_q;

  assert_hold_keeps_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !release_i && !accept_i) |=> tx_o);

endmodule

// File: rtl/lin_break_gen.sv
module lin_break_gen
  import lin_brk_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 8,
  parameter int unsigned LOW_BITS   = 13,
  parameter int unsigned HIGH_BITS  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick_i,
  input  logic start_i,
  input  logic bit_err_i,
  output logic tx_o,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned FIELD_N = field_ticks(OVERSAMPLE, LOW_BITS, HIGH_BITS);
  localparam int unsigned LAST_N  = last_count(OVERSAMPLE, LOW_BITS, HIGH_BITS);
  localparam int unsigned LOW_N   = low_ticks(OVERSAMPLE, LOW_BITS);
  localparam int unsigned CNT_W   = $clog2(FIELD_N);

  logic             active_w;
  logic             accept_w;
  logic             abort_w;
  logic             finish_w;
  logic             last_hit_w;
  logic             low_end_w;
  logic             hold_w;
  logic [CNT_W-1:0] cnt_w;

  lin_brk_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bit_err_i  (bit_err_i),
    .last_hit_i (last_hit_w),
    .active_o   (active_w),
    .accept_o   (accept_w),
    .abort_o    (abort_w),
    .finish_o   (finish_w),
    .done_o     (done_o)
  );

  lin_brk_counter #(
    .CNT_W (CNT_W),
    .LAST  (LAST_N),
    .LOW_N (LOW_N)
  ) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (accept_w || abort_w),
    .run_i      (active_w),
    .tick_i     (baud_tick_i),
    .cnt_o      (cnt_w),
    .low_end_o  (low_end_w),
    .last_hit_o (last_hit_w)
  );

  lin_brk_txguard guard_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept_w),
    .low_end_i (low_end_w),
    .release_i (abort_w || finish_w),
    .tx_o      (tx_o),
    .hold_o    (hold_w)
  );

  assign busy_o = active_w;

  assert_low_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_o |-> busy_o);

  assert_no_fall_in_delim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tx_o) |=> tx_o);

  assert_done_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (tx_o && !busy_o));

  assert_hold_past_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_w && busy_o) |-> (cnt_w >= CNT_W'(LOW_N)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !bit_err_i && !last_hit_w) |=> busy_o);

endmodule

// File: tb/lin_break_gen_tb_top.sv
module lin_break_gen_tb_top;

  function automatic int bench_low(input int os, input int bits);
    return os * bits;
  endfunction

  function automatic int bench_field(input int os, input int lo, input int hi);
    return bench_low(os, lo) + bench_low(os, hi);
  endfunction

  localparam int LOW   = bench_low(8, 13);
  localparam int FIELD = bench_field(8, 13, 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic start = 1'b0;
  logic bit_err = 1'b0;
  logic tx_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lin_break_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud_tick_i (tick),
    .start_i     (start),
    .bit_err_i   (bit_err),
    .tx_o        (tx_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic rand_tick(input int density);
    if (density <= 1) return 1'b1;
    return (($urandom % density) == 0);
  endfunction

  function automatic int pack3();
    return {29'd0, tx_o, busy_o, done_o};
  endfunction

  // one field; err_at < 0 means no error, restart_at < 0 means no restart
  task automatic run_frame(input int density, input int err_at, input int restart_at);
    int  n = 0;
    int  bad = 0;
    int  dones = 0;
    int  done_n = -1;
    bit  seen_high = 0;
    bit  fell = 0;
    bit  err_sent = 0;
    @(negedge clk);
    start = 1'b1;
    tick = rand_tick(density);
    @(negedge clk);
    start = 1'b0;
    check(tx_o == 1'b0 && busy_o == 1'b1, "R2", pack3(), 3'b010);
    for (int k = 0; k < 20000; k++) begin
      if (done_o) begin
        dones++;
        done_n = n;
      end
      if (!busy_o) break;
      if (tx_o != ((n < LOW) ? 1'b0 : 1'b1)) bad++;
      if (seen_high && !tx_o) fell = 1;
      if (tx_o) seen_high = 1;
      tick = rand_tick(density);
      start = (restart_at >= 0 && n >= restart_at && n < restart_at + 3);
      bit_err = (err_at >= 0 && n == err_at && !err_sent);
      if (bit_err) err_sent = 1;
      else if (tick) n++;
      @(negedge clk);
      start = 1'b0;
      bit_err = 1'b0;
    end
    if (err_at >= 0) begin
      // R7: abort leaves line high, no completion
      check(dones == 0 && tx_o && !busy_o, "R7", pack3(), 3'b100);
      check(bad == 0, "R4", bad, 0);
    end else begin
      check(dones == 1 && done_n == FIELD, "R6", done_n, FIELD);
      check(tx_o == 1'b1, "R6", tx_o, 1);
      check(bad == 0, "R4", bad, 0);
      check(!fell, "R5", fell, 0);
      if (restart_at >= 0) check(bad == 0 && done_n == FIELD, "R8", done_n, FIELD);
      @(negedge clk);
      check(done_o == 1'b0, "R6", done_o, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17_0C3D));
    #1;
    check(tx_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R1", pack3(), 3'b100);
    repeat (3) @(negedge clk);
    check(tx_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R1", pack3(), 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: errors while idle
    for (int i = 0; i < 6; i++) begin
      bit_err = 1'b1;
      tick = rand_tick(2);
      @(negedge clk);
      check(tx_o == 1'b1 && !busy_o && !done_o, "R9", pack3(), 3'b100);
    end
    bit_err = 1'b0;

    // directed patterns
    run_frame(1, -1, -1);
    run_frame(4, -1, -1);
    run_frame(1, -1, 50);
    run_frame(3, -1, LOW + 2);
    run_frame(1, 0, -1);
    run_frame(2, LOW + 5, -1);
    run_frame(1, FIELD - 1, -1);

    // R3: no ticks means no progress
    @(negedge clk);
    start = 1'b1;
    tick = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    check(busy_o == 1'b1 && tx_o == 1'b0, "R3", pack3(), 3'b010);
    bit_err = 1'b1;
    @(negedge clk);
    bit_err = 1'b0;
    check(!busy_o && tx_o && !done_o, "R7", pack3(), 3'b100);

    // random mix
    for (int f = 0; f < 12; f++) begin
      int d = 1 + ($urandom % 6);
      int e = (($urandom % 4) == 0) ? int'($urandom % FIELD) : -1;
      int r = (($urandom % 3) == 0) ? int'($urandom % FIELD) : -1;
      run_frame(d, e, r);
      repeat ($urandom % 4) @(negedge clk);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule